// File: doc/BRIEF.md
# Single-Channel DMA Controller with Request Selection

This block is one DMA channel. Software sets it up through a small register bus. Two byte-wide control registers hold the channel settings:

- the operating mode (stop at the end of a block, or wrap around as a ring buffer);
- a two-level request-source select;
- the unit size (one byte or one halfword);
- whether the source address and the destination address each advance or stay put;
- an enable bit.

Three more registers hold the source address, the destination address and the transfer count.

A rising edge on the selected request input latches a request flag. The channel then moves one unit through a simple memory master port: it reads the source, then writes the destination. It then updates the addresses and the count. At the end of each unit it pulses a per-unit completion output, so that another channel can chain from it. When the count runs out, a normal-mode channel turns itself off and pulses a block-complete output. A ring-mode channel instead reloads the addresses and the count it was given and stays enabled.

The primary source select picks one of four choices:

- a software start strobe, or a per-unit completion from a chained channel;
- a block completion from another channel;
- serial-receive-data-ready;
- the extended select field.

The extended field picks one of ten external event inputs. Its remaining codes select nothing.

Top module: `dmac_channel`

## Requirements
- R1: After reset, the control register at offset 0 and the one at offset 1 both read 0. Offset 0 holds, from bit 7 down: ring mode, request flag, 2-bit primary source select (bits 5:4), enable (bit 3), size (bit 2, 1 = byte, 0 = halfword), source advance (bit 1), destination advance (bit 0). Offset 1 holds the extended select in bits 3:0, and its bits 7:4 always read 0. Offsets 2, 3 and 4 hold the source address, the destination address and the count.
- R2: The request flag (offset 0 bit 6) sets on a rising edge of the selected request, but only while enable is 1. A register write with bit 6 = 0 clears it. A write with bit 6 = 1 leaves it unchanged. The start of a unit transfer clears it. A new request edge takes priority over both clears.
- R3: Primary select 00 takes `sw_start` or `chain_one_in`; 01 takes `chain_all_in`; 10 takes `serial_rx_rdy`. Edges on inputs that are not selected are ignored.
- R4: Primary select 11 with extended code k in 0..9 takes `ext_evt[k]`. Extended codes 10..15 select no source, so the flag never sets from them.
- R5: Each flagged request causes exactly one unit transfer: a read of the source address, then a write of the read data to the destination address. `mem_size8` is 1 for byte units, which are carried on data bits 7:0, and 0 for halfword units.
- R6: After each unit, an address whose advance bit is 1 grows by 1 for byte units or 2 for halfword units. An address whose advance bit is 0 stays fixed.
- R7: The count drops by one per unit. In normal mode the unit that brings it to 0 clears enable and pulses `all_done`, and later requests are ignored.
- R8: In ring mode the unit that brings the count to 0 reloads both addresses and the count with the values software last wrote, and enable stays 1.
- R9: `one_done` pulses once, for one cycle, at the acknowledged write of every unit.
- R10: Halfword accesses on the memory port always use an even address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr` |
| sw_start | input | 1 | Software start strobe (primary code 00) |
| chain_one_in | input | 1 | Per-unit completion from a chained channel (primary code 00) |
| chain_all_in | input | 1 | Block completion from another channel (primary code 01) |
| serial_rx_rdy | input | 1 | Serial receive data ready (primary code 10) |
| ext_evt | input | N_EXT | External event inputs (extended codes) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_size8 | output | 1 | 1 = byte access, 0 = halfword access |
| mem_addr | output | REG_W | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid together with `mem_ack` |
| mem_ack | input | 1 | Access acknowledge |
| one_done | output | 1 | Pulse at the end of each unit transfer |
| all_done | output | 1 | Pulse when a normal-mode block finishes |

## Verification
The assertions assume three things about the environment:

- software places halfword transfers on even start addresses;
- the memory stub answers every request within a bounded time;
- `mem_rdata` is valid in the acknowledge cycle.

The stimulus keeps every halfword vector on even addresses. It acknowledges in the same cycle as the request, except in one directed test that holds the acknowledge back on purpose. That test keeps the channel busy while a second request arrives, so that the held flag can be read back.

The request strobes are one-cycle pulses driven on the falling clock edge. Each is followed by enough idle cycles for the unit transfer to finish before the next stimulus.

// File: rtl/dmac_pkg.sv
// Package: shared offsets, field layout and state encoding for the DMA channel.
// Assumes the register bus decodes a 3-bit offset.
package dmac_pkg;
    localparam logic [2:0] OFS_CTL0 = 3'd0;
    localparam logic [2:0] OFS_CTL1 = 3'd1;
    localparam logic [2:0] OFS_SRC  = 3'd2;
    localparam logic [2:0] OFS_DST  = 3'd3;
    localparam logic [2:0] OFS_CNT  = 3'd4;

    typedef enum logic [1:0] {
        PRI_SOFT    = 2'b00,
        PRI_ALLDONE = 2'b01,
        PRI_SERIAL  = 2'b10,
        PRI_EXT     = 2'b11
    } pri_sel_e;

    typedef struct packed {
        logic     ring;
        logic     flag;
        pri_sel_e pri_sel;
        logic     en;
        logic     size8;
        logic     src_inc;
        logic     dst_inc;
    } ctl0_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/dmac_req_sel.sv
// Module: request selection.
// Detects rising edges on every raw request input, then routes the edge chosen by the
// primary and extended selects. Extended codes at or above N_EXT select nothing.
// Assumes request inputs are synchronous to clk.
module dmac_req_sel #(
    parameter int unsigned N_EXT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dmac_pkg::pri_sel_e pri_sel,
    input  logic [3:0]       ext_sel,
    input  logic             sw_start,
    input  logic             chain_one_in,
    input  logic             chain_all_in,
    input  logic             serial_rx_rdy,
    input  logic [N_EXT-1:0] ext_evt,
    output logic             req_edge
);
    import dmac_pkg::*;

    localparam int unsigned N_RAW = N_EXT + 4;

    logic [N_RAW-1:0] raw;
    logic [N_RAW-1:0] raw_prev;
    logic [N_RAW-1:0] rise;
    logic [N_EXT-1:0] ext_hit;

    assign raw  = {ext_evt, serial_rx_rdy, chain_all_in, chain_one_in, sw_start};
    assign rise = raw & ~raw_prev;

    // Purpose: remember last cycle's request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_prev <= '0;
        else        raw_prev <= raw;
    end

    // One decoder slice per external event input.
    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assign ext_hit[i] = rise[4+i] && (ext_sel == 4'(i));
    end

    // Purpose: route the selected edge to the request flag.
    always_comb begin
        unique case (pri_sel)
            PRI_SOFT:    req_edge = rise[0] | rise[1];
            PRI_ALLDONE: req_edge = rise[2];
            PRI_SERIAL:  req_edge = rise[3];
            default:     req_edge = |ext_hit;
        endcase
    end
endmodule

// File: rtl/dmac_regs.sv
// Module: control registers and request flag.
// Holds both control bytes. A request edge while enabled sets the flag; a software write
// of 0 to the flag bit, or the start of a unit transfer, clears it. The set takes
// priority. A software write to the enable bit takes priority over the hardware disable.
module dmac_regs (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          wbyte,
    input  logic                req_edge,
    input  logic                xfer_start,
    input  logic                hw_disable,
    output dmac_pkg::ctl0_t     ctl0,
    output logic [3:0]          ext_sel
);
    import dmac_pkg::*;

    logic wr0;
    logic wr1;

    assign wr0 = reg_wr && (reg_addr == OFS_CTL0);
    assign wr1 = reg_wr && (reg_addr == OFS_CTL1);

    // Purpose: update control fields, flag and extended select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0    <= '0;
            ext_sel <= '0;
        end else begin
            if (wr0) begin
                ctl0.ring    <= wbyte[7];
                ctl0.pri_sel <= pri_sel_e'(wbyte[5:4]);
                ctl0.en      <= wbyte[3];
                ctl0.size8   <= wbyte[2];
                ctl0.src_inc <= wbyte[1];
                ctl0.dst_inc <= wbyte[0];
            end else if (hw_disable) begin
                ctl0.en <= 1'b0;
            end
            if (req_edge && ctl0.en)
                ctl0.flag <= 1'b1;
            else if ((wr0 && !wbyte[6]) || xfer_start)
                ctl0.flag <= 1'b0;
            if (wr1)
                ext_sel <= wbyte[3:0];
        end
    end
endmodule

// File: rtl/dmac_xfer.sv
// Module: unit transfer sequencer.
// Starts a read-then-write unit when the flag and enable are both set, and steps the
// addresses and the count after the write. Software writes load both the working copy
// and the reload copy, and take priority over the sequencer's updates.
// Assumes halfword units start on even addresses.
module dmac_xfer #(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring,
    input  logic             flag,
    input  logic             en,
    input  logic             size8,
    input  logic             src_inc,
    input  logic             dst_inc,
    input  logic             wr_src,
    input  logic             wr_dst,
    input  logic             wr_cnt,
    input  logic [REG_W-1:0] wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             mem_ack,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_size8,
    output logic [REG_W-1:0] mem_addr,
    output logic [15:0]      mem_wdata,
    output logic             xfer_start,
    output logic             one_done,
    output logic             all_done,
    output logic [REG_W-1:0] src_addr,
    output logic [REG_W-1:0] dst_addr,
    output logic [REG_W-1:0] count
);
    import dmac_pkg::*;

    xfer_state_e      state;
    logic [REG_W-1:0] src_base, dst_base, cnt_base;
    logic [REG_W-1:0] step;
    logic [15:0]      data_q;
    logic             cur_size8;
    logic             last_unit;

    assign xfer_start = (state == ST_IDLE) && flag && en;
    assign step       = cur_size8 ? REG_W'(1) : REG_W'(2);
    assign last_unit  = (count == REG_W'(1));
    assign one_done   = (state == ST_WRITE) && mem_ack;
    assign all_done   = one_done && last_unit && !ring;

    assign mem_req   = (state != ST_IDLE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_size8 = cur_size8;
    assign mem_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
    assign mem_wdata = data_q;

    // Purpose: step through idle, read and write phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            data_q    <= '0;
            cur_size8 <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (xfer_start) begin
                    state     <= ST_READ;
                    cur_size8 <= size8;
                end
                ST_READ: if (mem_ack) begin
                    data_q <= mem_rdata;
                    state  <= ST_WRITE;
                end
                default: if (mem_ack) state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: maintain working and reload copies of the addresses and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0; dst_addr <= '0; count <= '0;
            src_base <= '0; dst_base <= '0; cnt_base <= '0;
        end else begin
            if (one_done) begin
                if (last_unit && ring) begin
                    src_addr <= src_base;
                    dst_addr <= dst_base;
                    count    <= cnt_base;
                end else begin
                    src_addr <= src_addr + (src_inc ? step : '0);
                    dst_addr <= dst_addr + (dst_inc ? step : '0);
                    count    <= count - REG_W'(1);
                end
            end
            if (wr_src) begin src_addr <= wdata; src_base <= wdata; end
            if (wr_dst) begin dst_addr <= wdata; dst_base <= wdata; end
            if (wr_cnt) begin count    <= wdata; cnt_base <= wdata; end
        end
    end
endmodule

// File: rtl/dmac_channel.sv
// Module: top of the single DMA channel.
// Ties together request selection, control registers and the transfer sequencer, and
// drives the register read mux. Assumes REG_W is at least 8.
module dmac_channel #(
    parameter int unsigned REG_W = 16,
    parameter int unsigned N_EXT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sw_start,
    input  logic             chain_one_in,
    input  logic             chain_all_in,
    input  logic             serial_rx_rdy,
    input  logic [N_EXT-1:0] ext_evt,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_size8,
    output logic [REG_W-1:0] mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             mem_ack,
    output logic             one_done,
    output logic             all_done
);
    import dmac_pkg::*;

    ctl0_t            ctl0_q;
    logic [3:0]       ext_sel_q;
    logic             req_edge;
    logic             xfer_start;
    logic [REG_W-1:0] src_addr, dst_addr, count;

    dmac_req_sel #(.N_EXT(N_EXT)) u_req (
        .clk(clk), .rst_n(rst_n), .pri_sel(ctl0_q.pri_sel), .ext_sel(ext_sel_q),
        .sw_start(sw_start), .chain_one_in(chain_one_in), .chain_all_in(chain_all_in),
        .serial_rx_rdy(serial_rx_rdy), .ext_evt(ext_evt), .req_edge(req_edge)
    );

    dmac_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .wbyte(reg_wdata[7:0]), .req_edge(req_edge), .xfer_start(xfer_start),
        .hw_disable(all_done), .ctl0(ctl0_q), .ext_sel(ext_sel_q)
    );

    dmac_xfer #(.REG_W(REG_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .ring(ctl0_q.ring), .flag(ctl0_q.flag),
        .en(ctl0_q.en), .size8(ctl0_q.size8), .src_inc(ctl0_q.src_inc),
        .dst_inc(ctl0_q.dst_inc),
        .wr_src(reg_wr && reg_addr == OFS_SRC), .wr_dst(reg_wr && reg_addr == OFS_DST),
        .wr_cnt(reg_wr && reg_addr == OFS_CNT), .wdata(reg_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size8(mem_size8), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .xfer_start(xfer_start), .one_done(one_done), .all_done(all_done),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count)
    );

    // Purpose: register read mux.
    always_comb begin
        unique case (reg_addr)
            OFS_CTL0: reg_rdata = REG_W'(ctl0_q);
            OFS_CTL1: reg_rdata = REG_W'(ext_sel_q);
            OFS_SRC:  reg_rdata = src_addr;
            OFS_DST:  reg_rdata = dst_addr;
            OFS_CNT:  reg_rdata = count;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_checker.sv
// Module: protocol checker for dmac_channel, attached with bind.
// Assumes the environment keeps halfword transfers on even start addresses.
module dmac_checker #(
    parameter int unsigned N_EXT = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [2:0]      reg_addr,
    input logic            reg_wbit6,
    input dmac_pkg::ctl0_t ctl0,
    input logic [3:0]      ext_sel,
    input logic            xfer_start,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic            mem_size8,
    input logic            mem_addr0,
    input logic            one_done,
    input logic            all_done
);
    logic wr0;
    assign wr0 = reg_wr && (reg_addr == 3'd0);

    assert_flag_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl0.en && !ctl0.flag) |=> !ctl0.flag);

    assert_flag_fall_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl0.flag) |-> $past((wr0 && !reg_wbit6) || xfer_start));

    assert_inhibited_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.pri_sel == dmac_pkg::PRI_EXT && 32'(ext_sel) >= N_EXT && !ctl0.flag)
        |=> !ctl0.flag);

    assert_start_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(ctl0.en && ctl0.flag));

    assert_normal_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (all_done && !wr0) |=> !ctl0.en);

    assert_all_done_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> (one_done && !ctl0.ring));

    assert_ring_keeps_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (one_done && ctl0.ring && ctl0.en && !wr0) |=> ctl0.en);

    assert_one_done_at_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        one_done |-> (mem_req && mem_we && mem_ack));

    assert_halfword_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_size8) |-> !mem_addr0);
endmodule

bind dmac_channel dmac_checker #(.N_EXT(N_EXT)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wbit6(reg_wdata[6]), .ctl0(ctl0_q), .ext_sel(ext_sel_q),
    .xfer_start(xfer_start), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_size8(mem_size8), .mem_addr0(mem_addr[0]), .one_done(one_done),
    .all_done(all_done)
);

// File: tb/test_dmac_channel.sv
`timescale 1ns/1ps
// Bench for dmac_channel: a vector table of block transfers, then directed tests.
module test_dmac_channel;
    localparam int REG_W = 16;
    localparam int N_EXT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic sw_start = 0, chain_one_in = 0, chain_all_in = 0, serial_rx_rdy = 0;
    logic [N_EXT-1:0] ext_evt = '0;
    logic mem_req, mem_we, mem_size8, mem_ack, one_done, all_done;
    logic [REG_W-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic ack_en = 1'b1;

    logic [7:0] mem [0:255];
    logic [7:0] exp_mem [0:255];
    int n_chk = 0, n_fail = 0;
    int n_one = 0, n_all = 0, n_misalign = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dmac_channel #(.REG_W(REG_W), .N_EXT(N_EXT)) i_dmac_channel (.*);

    assign mem_ack = mem_req && ack_en;
    assign mem_rdata = mem_size8 ? {8'h00, mem[mem_addr[7:0]]}
                                 : {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};

    // Memory stub and event counters.
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (!mem_size8) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
        end
        if (rst_n && one_done) n_one <= n_one + 1;
        if (rst_n && all_done) n_all <= n_all + 1;
        if (mem_req && !mem_size8 && mem_addr[0]) n_misalign <= n_misalign + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [REG_W-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic reg_read(input logic [2:0] a, output int v);
        @(negedge clk); reg_addr = a; #1 v = int'(reg_rdata);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Vector: {ring, size8, src_inc, dst_inc, count, requests, src, dst}
    localparam logic [35:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 1'b1, 8'd3, 8'd3, 8'h10, 8'h80},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd4, 8'd4, 8'h20, 8'h90},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'd2, 8'd4, 8'h05, 8'hA0},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd2, 8'd5, 8'h30, 8'hB0},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd3, 8'd4, 8'h11, 8'hC1},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 8'h3E, 8'hD0}
    };

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int v, base;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);

        // R1: reset values
        reg_read(3'd0, v); check("R1 ctl0 reset", v, 0);
        reg_read(3'd1, v); check("R1 ctl1 reset", v, 0);
        check("R1 idle bus", int'(mem_req), 0);
        reg_write(3'd1, 16'h00F3);
        reg_read(3'd1, v); check("R1 ctl1 high nibble", v, 3);
        reg_write(3'd1, 16'h000F);
        reg_write(3'd0, 16'h00BF);
        reg_read(3'd0, v); check("R1 ctl0 fields", v, 8'hBF);
        reg_write(3'd0, 16'h0000);

        // Vector table: R5 R6 R7 R8
        foreach (VEC[k]) begin
            logic ring, s8, si, di;
            int cnt, nreq, s, d, c, en, one0;
            {ring, s8, si, di} = VEC[k][35:32];
            cnt = int'(VEC[k][31:24]); nreq = int'(VEC[k][23:16]);
            s = int'(VEC[k][15:8]); d = int'(VEC[k][7:0]);
            for (int i = 0; i < 256; i++) begin
                mem[i] = 8'(i) ^ 8'hA5;
                exp_mem[i] = 8'(i) ^ 8'hA5;
            end
            reg_write(3'd0, 16'h0000);
            reg_write(3'd2, 16'(s));
            reg_write(3'd3, 16'(d));
            reg_write(3'd4, 16'(cnt));
            reg_write(3'd0, 16'({ring, 1'b0, 2'b00, 1'b1, s8, si, di}));
            one0 = n_one;
            for (int r = 0; r < nreq; r++) begin
                @(negedge clk); sw_start = 1;
                @(negedge clk); sw_start = 0;
                wait_cyc(8);
            end
            // bench model of the expected outcome
            c = cnt; en = 1; base = 0;
            for (int r = 0; r < nreq; r++) begin
                if (en == 0) continue;
                exp_mem[d[7:0]] = exp_mem[s[7:0]];
                if (!s8) exp_mem[8'(d + 1)] = exp_mem[8'(s + 1)];
                base++;
                c--;
                if (c == 0) begin
                    if (ring) begin
                        c = cnt; s = int'(VEC[k][15:8]); d = int'(VEC[k][7:0]);
                        continue;
                    end
                    en = 0;
                end
                if (si) s += s8 ? 1 : 2;
                if (di) d += s8 ? 1 : 2;
            end
            reg_read(3'd2, v); check($sformatf("R6 vec%0d src", k), v, s);
            reg_read(3'd3, v); check($sformatf("R6 vec%0d dst", k), v, d);
            reg_read(3'd4, v); check($sformatf("R7 R8 vec%0d count", k), v, c);
            reg_read(3'd0, v); check($sformatf("R7 R8 vec%0d enable", k), (v >> 3) & 1, en);
            check($sformatf("R9 vec%0d unit pulses", k), n_one - one0, base);
            v = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) v++;
            check($sformatf("R5 vec%0d memory mismatches", k), v, 0);
        end
        check("R7 block completions", n_all, 4);
        reg_write(3'd0, 16'h0000);

        // R2: flag held while busy, write-1 keeps, write-0 clears
        reg_write(3'd2, 16'h0040); reg_write(3'd3, 16'h0060); reg_write(3'd4, 16'd200);
        reg_write(3'd0, 16'h0028);
        ack_en = 0;
        @(negedge clk); serial_rx_rdy = 1; @(negedge clk); serial_rx_rdy = 0;
        wait_cyc(3);
        @(negedge clk); serial_rx_rdy = 1; @(negedge clk); serial_rx_rdy = 0;
        wait_cyc(2);
        reg_read(3'd0, v); check("R2 flag set during busy", (v >> 6) & 1, 1);
        reg_write(3'd0, 16'h0068);
        reg_read(3'd0, v); check("R2 write 1 keeps flag", (v >> 6) & 1, 1);
        reg_write(3'd0, 16'h0028);
        reg_read(3'd0, v); check("R2 write 0 clears flag", (v >> 6) & 1, 0);
        base = n_one;
        ack_en = 1;
        wait_cyc(8);
        check("R2 cleared flag gives no extra unit", n_one - base, 1);

        // R2: no set while disabled
        reg_write(3'd0, 16'h0020);
        base = n_one;
        @(negedge clk); serial_rx_rdy = 1; @(negedge clk); serial_rx_rdy = 0;
        wait_cyc(8);
        reg_read(3'd0, v); check("R2 flag stays 0 when disabled", (v >> 6) & 1, 0);
        check("R2 no unit when disabled", n_one - base, 0);

        // R3: primary codes
        reg_write(3'd0, 16'h0018);
        base = n_one;
        @(negedge clk); chain_all_in = 1; @(negedge clk); chain_all_in = 0; wait_cyc(8);
        check("R3 code 01 takes block completion", n_one - base, 1);
        @(negedge clk); serial_rx_rdy = 1; @(negedge clk); serial_rx_rdy = 0; wait_cyc(8);
        check("R3 code 01 ignores serial", n_one - base, 1);
        reg_write(3'd0, 16'h0008);
        base = n_one;
        @(negedge clk); chain_one_in = 1; @(negedge clk); chain_one_in = 0; wait_cyc(8);
        check("R3 code 00 takes chained unit", n_one - base, 1);
        @(negedge clk); chain_all_in = 1; @(negedge clk); chain_all_in = 0; wait_cyc(8);
        check("R3 code 00 ignores block completion", n_one - base, 1);

        // R4: extended codes
        reg_write(3'd1, 16'h0007);
        reg_write(3'd0, 16'h0038);
        base = n_one;
        @(negedge clk); ext_evt[7] = 1; @(negedge clk); ext_evt[7] = 0; wait_cyc(8);
        check("R4 ext code 7 selects event 7", n_one - base, 1);
        @(negedge clk); ext_evt[6] = 1; @(negedge clk); ext_evt[6] = 0; wait_cyc(8);
        check("R4 ext code 7 ignores event 6", n_one - base, 1);
        reg_write(3'd1, 16'h000A);
        @(negedge clk); ext_evt = '1; @(negedge clk); ext_evt = '0; wait_cyc(8);
        reg_read(3'd0, v); check("R4 inhibited code sets no flag", (v >> 6) & 1, 0);
        check("R4 inhibited code gives no unit", n_one - base, 1);

        // R10: alignment of halfword accesses
        check("R10 misaligned halfword accesses", n_misalign, 0);

        finish_run();
    end
endmodule